// File: doc/BRIEF.md
# Forty-Bit Shift and Bit-Field Unit

This block is the shift stage of a DSP datapath whose accumulators are 40 bits wide. Each accepted request performs one of six operations on a 40-bit operand: an arithmetic shift, a logical shift, a rotate, a normalization count, a bit-field extract or a bit-field deposit. Shifts and rotates take a signed amount. Positive values move bits toward the most significant end and negative values move them toward bit 0. Extract and deposit take a start position and a length.

The result and two status flags are registered when a request is accepted. They appear one clock later, together with an output valid strobe, and stay unchanged until the next accepted request. Normalization returns the number of left shifts needed to remove redundant copies of the sign bit. This lets software scale an accumulator before storing it.

Top module: `fieldshift_unit`

## Requirements
- R1: With op=0 (arithmetic shift), a positive `amount` s shifts `opa` left by s with zero fill. A negative s shifts right by |s| and fills with copies of bit 39. `amount` is 7-bit two's complement (-64..63). When |s| is 40 or more, a left shift gives all zeros and a right shift gives 40 copies of bit 39.
- R2: With op=1 (logical shift), the result is the same as in R1, except that a right shift fills with zeros and a magnitude of 40 or more gives all zeros.
- R3: With op=2 (rotate), a positive s rotates `opa` left by s mod 40. A negative s rotates it right by |s| mod 40.
- R4: With op=3 (normalize), the result is the count of consecutive bits, from bit 38 downward, that equal bit 39. The count stops at the first bit that differs. It is zero-extended to 40 bits. An operand of all zeros or all ones gives 39.
- R5: With op=4 and `sext`=0 (extract), bit i of the result is `opa[fpos+i]` for i < `flen`, and 0 otherwise. Source positions above 39 read as 0. A length of 0 gives zero, and a length of 40 or more takes every remaining bit.
- R6: With op=4 and `sext`=1, the field is taken as in R5. If flen is 1 to 39, all result bits at i >= flen are set to the top field bit, `opa[fpos+flen-1]`, which reads as 0 when that position is above 39.
- R7: With op=5 (deposit), bit i of the result is `opa[i-fpos]` when fpos <= i < fpos+flen, and `opb[i]` otherwise. Field bits that would land above bit 39 are dropped.
- R8: `zero_flag` is 1 exactly when the registered result is all zeros.
- R9: `ovf_flag` is 1 only for op=0 with s > 0, and then exactly when bit 39 of the result differs from bit 39 of `opa`.
- R10: `out_valid` is 1 in the cycle after each accepted request (`in_valid`=1) and 0 otherwise. Result and flags change only on an accepted request and are held otherwise.
- R11: While `rst` is 1, the registers clear. After reset, `out_valid`, `result`, `zero_flag` and `ovf_flag` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request accepted on this edge |
| op | input | 3 | Operation select (0..5) |
| sext | input | 1 | Sign-extend the extracted field |
| opa | input | 40 | Main operand and deposit source |
| opb | input | 40 | Deposit destination |
| amount | input | 7 | Signed shift or rotate amount |
| fpos | input | 6 | Field start bit |
| flen | input | 6 | Field length |
| out_valid | output | 1 | Registered result is new |
| result | output | 40 | Registered result |
| zero_flag | output | 1 | Result is zero |
| ovf_flag | output | 1 | Left arithmetic shift changed the sign |

## Verification
Every result and both flags are due exactly one rising edge after the request is presented. The bench drives each request on a falling edge and reads the result, the flags and `out_valid` on the next falling edge, after the single capturing edge. The hold behaviour is checked by dropping `in_valid` and changing every input. The bench waits two edges and then compares the outputs with the last accepted answer.

// File: rtl/fs_pkg.sv
package fs_pkg;
  typedef enum logic [2:0] {
    FS_ASH  = 3'd0,
    FS_LSH  = 3'd1,
    FS_ROT  = 3'd2,
    FS_NORM = 3'd3,
    FS_EXT  = 3'd4,
    FS_DEP  = 3'd5
  } fs_op_e;
endpackage

// File: rtl/fs_barrel.sv
module fs_barrel #(
  parameter int W  = 40,
  parameter int AW = 7
) (
  input  logic [W-1:0]  a,
  input  logic [AW-1:0] amt,
  output logic [W-1:0]  ash_o,
  output logic [W-1:0]  lsh_o,
  output logic [W-1:0]  rot_o
);
  localparam int MW = AW + 1;

  logic          neg;
  logic [MW-1:0] mag;
  logic          big;
  logic [W-1:0]  left_s, right_l, right_a;
  logic [2*W-1:0] dbl;
  int            mag_i, rem, rl;

  always_comb begin
    neg   = amt[AW-1];
    mag   = neg ? (MW'(0) - {amt[AW-1], amt}) : {1'b0, amt};
    mag_i = int'(mag);
    big   = (mag_i >= W);
    left_s  = big ? '0 : (a << mag);
    right_l = big ? '0 : (a >> mag);
    right_a = big ? {W{a[W-1]}} : W'($signed(a) >>> mag);
    ash_o = neg ? right_a : left_s;
    lsh_o = neg ? right_l : left_s;
    rem   = mag_i % W;
    rl    = (neg && rem != 0) ? (W - rem) : rem;
    dbl   = {a, a} << rl;
    rot_o = dbl[2*W-1:W];
  end
endmodule

// File: rtl/fs_norm.sv
module fs_norm #(
  parameter int W = 40
) (
  input  logic [W-1:0] a,
  output logic [W-1:0] norm_o
);
  localparam int CW = $clog2(W);

  logic [W-2:0] same;
  logic [CW-1:0] cnt;
  logic run;

  for (genvar g = 0; g < W - 1; g++) begin : g_same
    assign same[g] = (a[g] == a[W-1]);
  end

  always_comb begin
    cnt = '0;
    run = 1'b1;
    for (int i = W - 2; i >= 0; i--) begin
      if (run && same[i]) cnt = cnt + CW'(1);
      else run = 1'b0;
    end
    norm_o = {{(W-CW){1'b0}}, cnt};
  end
endmodule

// File: rtl/fs_field.sv
module fs_field #(
  parameter int W  = 40,
  parameter int PW = 6,
  parameter int LW = 6
) (
  input  logic [W-1:0]  a,
  input  logic [W-1:0]  b,
  input  logic [PW-1:0] pos,
  input  logic [LW-1:0] len,
  input  logic          sext,
  output logic [W-1:0]  ext_o,
  output logic [W-1:0]  dep_o
);
  logic [W-1:0] mask, topm, raw, pmask;
  logic         sb;

  always_comb begin
    mask  = ~({W{1'b1}} << len);
    topm  = mask & ~(mask >> 1);
    raw   = (a >> pos) & mask;
    sb    = |(raw & topm);
    ext_o = raw | ((sext && sb) ? ~mask : '0);
    pmask = mask << pos;
    dep_o = (b & ~pmask) | ((a & mask) << pos);
  end
endmodule

// File: rtl/fieldshift_unit.sv
module fieldshift_unit
  import fs_pkg::*;
#(
  parameter int W  = 40,
  parameter int AW = 7,
  parameter int PW = 6,
  parameter int LW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [2:0]    op,
  input  logic          sext,
  input  logic [W-1:0]  opa,
  input  logic [W-1:0]  opb,
  input  logic [AW-1:0] amount,
  input  logic [PW-1:0] fpos,
  input  logic [LW-1:0] flen,
  output logic          out_valid,
  output logic [W-1:0]  result,
  output logic          zero_flag,
  output logic          ovf_flag
);
  logic [W-1:0] ash_r, lsh_r, rot_r, norm_r, ext_r, dep_r;
  logic [W-1:0] nxt;
  logic         nxt_ovf;
  fs_op_e       opc;

  fs_barrel #(.W(W), .AW(AW)) u_barrel (
    .a(opa), .amt(amount), .ash_o(ash_r), .lsh_o(lsh_r), .rot_o(rot_r)
  );

  fs_norm #(.W(W)) u_norm (.a(opa), .norm_o(norm_r));

  fs_field #(.W(W), .PW(PW), .LW(LW)) u_field (
    .a(opa), .b(opb), .pos(fpos), .len(flen), .sext(sext),
    .ext_o(ext_r), .dep_o(dep_r)
  );

  always_comb begin
    opc = fs_op_e'(op);
    unique case (opc)
      FS_ASH:  nxt = ash_r;
      FS_LSH:  nxt = lsh_r;
      FS_ROT:  nxt = rot_r;
      FS_NORM: nxt = norm_r;
      FS_EXT:  nxt = ext_r;
      FS_DEP:  nxt = dep_r;
      default: nxt = '0;
    endcase
    nxt_ovf = (opc == FS_ASH) && !amount[AW-1] && (amount != '0)
              && (nxt[W-1] != opa[W-1]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
      zero_flag <= 1'b0;
      ovf_flag  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result    <= nxt;
        zero_flag <= (nxt == '0);
        ovf_flag  <= nxt_ovf;
      end
    end
  end
endmodule

// File: rtl/fieldshift_unit_chk.sv
module fieldshift_unit_chk #(
  parameter int W  = 40,
  parameter int AW = 7
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic [2:0]    op,
  input logic [AW-1:0] amount,
  input logic          out_valid,
  input logic [W-1:0]  result,
  input logic          zero_flag,
  input logic          ovf_flag
);
  logic lsh_big, ash_left;
  always_comb begin
    lsh_big  = (int'($signed(amount)) >= W) || (int'($signed(amount)) <= -W);
    ash_left = (op == 3'd0) && !amount[AW-1] && (amount != '0);
  end

  assert_reset_clear_R11: assert property (@(posedge clk)
    rst |=> (!out_valid && result == '0 && !zero_flag && !ovf_flag));

  assert_valid_follow_R10: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  assert_valid_idle_R10: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(result) && $stable(zero_flag) && $stable(ovf_flag)));

  assert_zero_flag_R8: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (zero_flag == (result == '0)));

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !ash_left) |=> !ovf_flag);

  assert_norm_range_R4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 3'd3) |=> (result <= W'(W - 1)));

  assert_lsh_flush_R2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 3'd1 && lsh_big) |=> (result == '0));
endmodule

bind fieldshift_unit fieldshift_unit_chk #(.W(W), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .amount(amount),
  .out_valid(out_valid), .result(result), .zero_flag(zero_flag),
  .ovf_flag(ovf_flag)
);

// File: tb/fieldshift_unit_tb.sv
`timescale 1ns/1ps
module fieldshift_unit_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [2:0]  op;
  logic        sext;
  logic [39:0] opa, opb;
  logic [6:0]  amount;
  logic [5:0]  fpos, flen;
  logic        out_valid;
  logic [39:0] result;
  logic        zero_flag, ovf_flag;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  fieldshift_unit u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .sext(sext),
    .opa(opa), .opb(opb), .amount(amount), .fpos(fpos), .flen(flen),
    .out_valid(out_valid), .result(result), .zero_flag(zero_flag),
    .ovf_flag(ovf_flag)
  );

  task automatic chk(input string tag, input logic [39:0] act, input logic [39:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [39:0] opnd(input int k);
    case (k)
      0: return 40'h00_0000_0001;
      1: return 40'h80_0000_0001;
      2: return 40'h7F_FFFF_FFFE;
      3: return 40'h12_3456_789A;
      4: return 40'hFF_FFFF_FFFF;
      default: return 40'h40_0000_0000;
    endcase
  endfunction

  // kind 0 arithmetic, 1 logical, 2 rotate
  function automatic logic [39:0] m_shift(input logic [39:0] a, input int s, input int kind);
    logic [39:0] r;
    for (int i = 0; i < 40; i++) begin
      int src;
      if (kind == 2) begin
        src = ((i - s) % 40 + 40) % 40;
        r[i] = a[src];
      end else begin
        src = i - s;
        if (src < 0) r[i] = 1'b0;
        else if (src > 39) r[i] = (kind == 0) ? a[39] : 1'b0;
        else r[i] = a[src];
      end
    end
    return r;
  endfunction

  function automatic logic [39:0] m_norm(input logic [39:0] a);
    int c = 0;
    for (int i = 38; i >= 0; i--) begin
      if (a[i] != a[39]) break;
      c++;
    end
    return 40'(c);
  endfunction

  function automatic logic [39:0] m_ext(input logic [39:0] a, input int p, input int l, input bit sx);
    logic [39:0] r;
    logic top;
    top = (l > 0 && p + l - 1 < 40) ? a[p+l-1] : 1'b0;
    for (int i = 0; i < 40; i++) begin
      if (i < l) r[i] = (p + i < 40) ? a[p+i] : 1'b0;
      else r[i] = (sx && l > 0 && l < 40) ? top : 1'b0;
    end
    return r;
  endfunction

  function automatic logic [39:0] m_dep(input logic [39:0] a, input logic [39:0] b, input int p, input int l);
    logic [39:0] r;
    for (int i = 0; i < 40; i++)
      r[i] = (i >= p && i < p + l) ? a[i-p] : b[i];
    return r;
  endfunction

  task automatic run(input string tag, input int o, input bit sx, input logic [39:0] a,
                     input logic [39:0] b, input int s, input int p, input int l,
                     input logic [39:0] exp);
    logic exp_ovf;
    @(negedge clk);
    in_valid = 1'b1; op = 3'(o); sext = sx; opa = a; opb = b;
    amount = 7'(s); fpos = 6'(p); flen = 6'(l);
    @(negedge clk);
    exp_ovf = (o == 0) && (s > 0) && (exp[39] != a[39]);
    chk(tag, result, exp);
    chk("R8 zero_flag", 40'(zero_flag), 40'(exp == 40'd0));
    chk("R9 ovf_flag", 40'(ovf_flag), 40'(exp_ovf));
    chk("R10 out_valid", 40'(out_valid), 40'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [39:0] last;
    rst = 1'b1; in_valid = 1'b0; op = 3'd0; sext = 1'b0;
    opa = '0; opb = '0; amount = '0; fpos = '0; flen = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11: cleared state after reset
    chk("R11 out_valid", 40'(out_valid), 40'd0);
    chk("R11 result", result, 40'd0);
    chk("R11 flags", {38'd0, zero_flag, ovf_flag}, 40'd0);

    // R1, R2, R3: every amount over several operands
    for (int k = 0; k < 6; k++)
      for (int s = -64; s < 64; s++) begin
        run("R1 ash", 0, 1'b0, opnd(k), '0, s, 0, 0, m_shift(opnd(k), s, 0));
        run("R2 lsh", 1, 1'b0, opnd(k), '0, s, 0, 0, m_shift(opnd(k), s, 1));
        run("R3 rot", 2, 1'b0, opnd(k), '0, s, 0, 0, m_shift(opnd(k), s, 2));
      end

    // R4: single-bit and single-hole patterns, all zeros, all ones
    for (int i = 0; i < 40; i++) begin
      logic [39:0] p1 = 40'd1 << i;
      run("R4 norm", 3, 1'b0, p1, '0, 0, 0, 0, m_norm(p1));
      run("R4 norm", 3, 1'b0, ~p1, '0, 0, 0, 0, m_norm(~p1));
      run("R4 norm", 3, 1'b0, p1 ^ 40'h00_5555_AAAA, '0, 0, 0, 0, m_norm(p1 ^ 40'h00_5555_AAAA));
    end
    run("R4 norm zeros", 3, 1'b0, 40'd0, '0, 0, 0, 0, 40'd39);
    run("R4 norm ones", 3, 1'b0, {40{1'b1}}, '0, 0, 0, 0, 40'd39);

    // R5, R6, R7: positions and lengths across and beyond the word
    for (int p = 0; p < 43; p++)
      for (int l = 0; l < 43; l++) begin
        run("R5 extract zero", 4, 1'b0, 40'hA5_C3F0_0F96, '0, 0, p, l,
            m_ext(40'hA5_C3F0_0F96, p, l, 1'b0));
        run("R6 extract sign", 4, 1'b1, 40'hB6_9E3C_71E5, '0, 0, p, l,
            m_ext(40'hB6_9E3C_71E5, p, l, 1'b1));
        run("R7 deposit", 5, 1'b0, 40'h5A_0FF0_C3A5, 40'hC3_3CA5_5A96, 0, p, l,
            m_dep(40'h5A_0FF0_C3A5, 40'hC3_3CA5_5A96, p, l));
      end

    // R10: idle cycles hold the last answer and clear out_valid
    run("R1 ash hold setup", 0, 1'b0, 40'h40_0000_0000, '0, 1, 0, 0, 40'h80_0000_0000);
    last = 40'h80_0000_0000;
    in_valid = 1'b0; op = 3'd1; opa = 40'h12_3456_789A; amount = 7'd3;
    @(negedge clk);
    @(negedge clk);
    chk("R10 idle out_valid", 40'(out_valid), 40'd0);
    chk("R10 idle result held", result, last);
    chk("R10 idle ovf held", 40'(ovf_flag), 40'd1);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule